// File: doc/BRIEF.md
# Branch Current Alarm Monitor

This block supervises a single branch circuit. It holds the most recent current sample. It compares that sample against thresholds that are set as a percentage of the breaker rating, and it keeps a 16-bit alarm status word. A run-state machine decides whether the load is running. Once the load has been seen running, four graded latching alarms (two over-current levels and two under-current levels) become armed. Each latching alarm fires only after its condition has persisted for its own number of seconds. The run-state machine also records the moment the load drops away.

Two further alarms do not latch. They follow the current, with a hysteresis band, around their own upper and lower setpoints. Software reads the status word from a combinational read port. It clears latched bits by writing zero to them through a one-cycle write strobe. All time bases come from an external one-second tick. Samples arrive with a valid strobe, roughly every 2.5 s.

Top module: `branch_alarm_monitor`

## Requirements
- R1: After reset the status word reads 0x0000 and the load is not declared running, so no latching alarm and no load-lost bit can set until a run declaration has happened.
- R2: Status word layout: bit 0 very-high latched, bit 1 high latched, bit 2 low latched, bit 3 very-low latched, bit 4 load-lost latched, bit 8 upper non-latching, bit 9 lower non-latching; bits 5-7 and 10-15 always read 0.
- R3: A write with a 0 in any of bits 0-4 clears that bit on the next clock edge. A 1 in the write data leaves the bit unchanged. Written values of bits 8 and 9 have no effect on them.
- R4: The load is declared running once the held sample has not been below the very-low threshold for `on_secs` ticks in a row. Latching alarms (bits 0-3) are evaluated only while the load is declared running.
- R5: While the load is running, a held sample below the very-low threshold for `off_secs` ticks in a row declares the load lost and sets bit 4. The load then leaves the running state. Bit 4 can never set unless the load was running before.
- R6: Each latching alarm sets once its condition has held for its own delay in ticks. A lapse of the condition restarts its count from zero. A delay of 0 sets the alarm as soon as a qualifying sample is held.
- R7: Each threshold in amps equals floor(rating × percent / 100). Over-current conditions use strictly greater-than and under-current conditions use strictly less-than.
- R8: The upper non-latching bit sets when the sample exceeds its threshold T. It clears when the sample falls below T − floor(T × hyst / 100). Between the two levels it keeps its value.
- R9: The lower non-latching bit sets when the sample is below its threshold T. It clears when the sample rises above T + floor(T × hyst / 100). Between the two levels it keeps its value.
- R10: A latched bit stays 1 until it is cleared by a write. If the bit is cleared while its condition still holds, it sets again only after a new full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse each second |
| sample_vld | input | 1 | Strobe that loads `sample_amps` |
| sample_amps | input | CUR_W | Measured branch current in amps |
| rating_amps | input | CUR_W | Breaker rating in amps |
| vhi_pct | input | PCT_W | Very-high latching threshold, percent of rating |
| hi_pct | input | PCT_W | High latching threshold, percent of rating |
| lo_pct | input | PCT_W | Low latching threshold, percent of rating |
| vlo_pct | input | PCT_W | Very-low latching threshold, percent of rating |
| nl_up_pct | input | PCT_W | Upper non-latching threshold, percent of rating |
| nl_dn_pct | input | PCT_W | Lower non-latching threshold, percent of rating |
| band_pct | input | PCT_W | Hysteresis, percent of the non-latching setpoint |
| vhi_secs | input | TIME_W | Very-high persistence delay in seconds |
| hi_secs | input | TIME_W | High persistence delay in seconds |
| lo_secs | input | TIME_W | Low persistence delay in seconds |
| vlo_secs | input | TIME_W | Very-low persistence delay in seconds |
| on_secs | input | TIME_W | Seconds needed to declare the load running |
| off_secs | input | TIME_W | Seconds needed to declare the load lost |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Status write data; zeros clear latched bits |
| rd_status | output | 16 | Alarm status word |

## Verification
The bench builds the monitor with 8-bit currents, 7-bit percentages and 4-bit second counters. With these widths it can sweep every current value from 0 to 255 upwards and downwards for several rating, setpoint and hysteresis combinations. Those sweeps reach every floor-rounding and strict-compare boundary of both non-latching alarms. A short timer width keeps every delay, run and load-lost sequence to a few ticks. That makes it practical to step through arming, per-level persistence, restart after a lapse, clear-while-active and re-arming after a load-lost declaration tick by tick.

// File: rtl/ba_pkg.sv
`timescale 1ns/1ps
package ba_pkg;
   typedef enum logic [1:0] {
      RUN_IDLE = 2'd0,
      RUN_ON   = 2'd1,
      RUN_LOST = 2'd2
   } run_t;

   localparam int STS_W    = 16;
   localparam int N_LATCH  = 4;
   localparam int N_THR    = 6;
   // threshold slots
   localparam int T_VHI = 0;
   localparam int T_HI  = 1;
   localparam int T_LO  = 2;
   localparam int T_VLO = 3;
   localparam int T_NUP = 4;
   localparam int T_NDN = 5;
endpackage

// File: rtl/ba_scale.sv
`timescale 1ns/1ps
module ba_scale #(
   parameter int AW = 12,
   parameter int PW = 8,
   parameter int OW = 20
) (
   input  logic [AW-1:0] a,
   input  logic [PW-1:0] pct,
   output logic [OW-1:0] y
);
   localparam int PRW = AW + PW;

   if (PRW < 8) begin : g_bad_width
      $error("ba_scale: product width too small for percent division");
   end

   logic [PRW-1:0] prod;
   logic [PRW-1:0] quot;

   assign prod = {{PW{1'b0}}, a} * {{AW{1'b0}}, pct};
   assign quot = prod / PRW'(100);
   assign y    = OW'(quot);
endmodule

// File: rtl/ba_timer.sv
`timescale 1ns/1ps
module ba_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          cond,
   input  logic          restart,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   if (TW < 1) begin : g_bad_tw
      $error("ba_timer: TW must be at least 1");
   end

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!cond || restart)
         cnt_q <= '0;
      else if (tick && (cnt_q < limit))
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = cond && (cnt_q >= limit);
endmodule

// File: rtl/ba_hyst.sv
`timescale 1ns/1ps
module ba_hyst #(
   parameter int XW      = 20,
   parameter bit UP_SIDE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [XW-1:0] cur,
   input  logic [XW-1:0] thr,
   input  logic [XW-1:0] band,
   output logic          flag
);
   logic          set_c;
   logic          clr_c;
   logic [XW:0]   sum_c;
   logic          flag_q;

   if (UP_SIDE) begin : g_up
      // cur + band < thr  <=>  cur < thr - band, with no underflow
      assign sum_c = {1'b0, cur} + {1'b0, band};
      assign set_c = cur > thr;
      assign clr_c = sum_c < {1'b0, thr};
   end else begin : g_dn
      assign sum_c = {1'b0, thr} + {1'b0, band};
      assign set_c = cur < thr;
      assign clr_c = {1'b0, cur} > sum_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (!en)
         flag_q <= 1'b0;
      else if (set_c)
         flag_q <= 1'b1;
      else if (clr_c)
         flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/branch_alarm_monitor.sv
`timescale 1ns/1ps
module branch_alarm_monitor
   import ba_pkg::*;
#(
   parameter int CUR_W  = 12,
   parameter int PCT_W  = 8,
   parameter int TIME_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              sample_vld,
   input  logic [CUR_W-1:0]  sample_amps,
   input  logic [CUR_W-1:0]  rating_amps,
   input  logic [PCT_W-1:0]  vhi_pct,
   input  logic [PCT_W-1:0]  hi_pct,
   input  logic [PCT_W-1:0]  lo_pct,
   input  logic [PCT_W-1:0]  vlo_pct,
   input  logic [PCT_W-1:0]  nl_up_pct,
   input  logic [PCT_W-1:0]  nl_dn_pct,
   input  logic [PCT_W-1:0]  band_pct,
   input  logic [TIME_W-1:0] vhi_secs,
   input  logic [TIME_W-1:0] hi_secs,
   input  logic [TIME_W-1:0] lo_secs,
   input  logic [TIME_W-1:0] vlo_secs,
   input  logic [TIME_W-1:0] on_secs,
   input  logic [TIME_W-1:0] off_secs,
   input  logic              wr_en,
   input  logic [STS_W-1:0]  wr_data,
   output logic [STS_W-1:0]  rd_status
);
   localparam int XW = CUR_W + PCT_W;

   if (CUR_W < 2) begin : g_bad_cur
      $error("branch_alarm_monitor: CUR_W must be at least 2");
   end
   if (PCT_W < 7) begin : g_bad_pct
      $error("branch_alarm_monitor: PCT_W must hold 100");
   end
   if (TIME_W < 1) begin : g_bad_time
      $error("branch_alarm_monitor: TIME_W must be at least 1");
   end

   // ---------------- sample hold ----------------
   logic [CUR_W-1:0] cur_q;
   logic             have_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         have_q <= 1'b0;
      end else if (sample_vld) begin
         cur_q  <= sample_amps;
         have_q <= 1'b1;
      end
   end

   logic [XW-1:0] cur_x;
   assign cur_x = XW'(cur_q);

   // ---------------- threshold scaling ----------------
   logic [PCT_W-1:0] pct_arr [N_THR];
   logic [XW-1:0]    thr_arr [N_THR];

   assign pct_arr[T_VHI] = vhi_pct;
   assign pct_arr[T_HI]  = hi_pct;
   assign pct_arr[T_LO]  = lo_pct;
   assign pct_arr[T_VLO] = vlo_pct;
   assign pct_arr[T_NUP] = nl_up_pct;
   assign pct_arr[T_NDN] = nl_dn_pct;

   for (genvar g = 0; g < N_THR; g++) begin : g_thr
      ba_scale #(.AW(CUR_W), .PW(PCT_W), .OW(XW)) u_scale (
         .a   (rating_amps),
         .pct (pct_arr[g]),
         .y   (thr_arr[g])
      );
   end

   logic [XW-1:0] band_up;
   logic [XW-1:0] band_dn;

   ba_scale #(.AW(XW), .PW(PCT_W), .OW(XW)) u_band_up (
      .a (thr_arr[T_NUP]), .pct (band_pct), .y (band_up)
   );
   ba_scale #(.AW(XW), .PW(PCT_W), .OW(XW)) u_band_dn (
      .a (thr_arr[T_NDN]), .pct (band_pct), .y (band_dn)
   );

   // ---------------- run state ----------------
   run_t run_q;
   logic run_on;
   logic below_vlo;
   logic on_cond, off_cond, on_exp, off_exp;

   assign run_on    = (run_q == RUN_ON);
   assign below_vlo = cur_x < thr_arr[T_VLO];
   assign on_cond   = have_q && !run_on && !below_vlo;
   assign off_cond  = have_q && run_on && below_vlo;

   ba_timer #(.TW(TIME_W)) u_on_tmr (
      .clk (clk), .rst_n (rst_n), .tick (sec_tick), .cond (on_cond),
      .restart (1'b0), .limit (on_secs), .expired (on_exp)
   );
   ba_timer #(.TW(TIME_W)) u_off_tmr (
      .clk (clk), .rst_n (rst_n), .tick (sec_tick), .cond (off_cond),
      .restart (1'b0), .limit (off_secs), .expired (off_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= RUN_IDLE;
      else if (on_exp)
         run_q <= RUN_ON;
      else if (off_exp)
         run_q <= RUN_LOST;
   end

   // ---------------- latching alarms ----------------
   logic [N_LATCH-1:0] raw_c;
   logic [N_LATCH-1:0] lat_exp;
   logic [TIME_W-1:0]  dly_arr [N_LATCH];
   logic [N_LATCH:0]   clr_req;
   logic [N_LATCH:0]   set_req;
   logic [N_LATCH:0]   lat_q;

   assign raw_c[T_VHI] = cur_x > thr_arr[T_VHI];
   assign raw_c[T_HI]  = cur_x > thr_arr[T_HI];
   assign raw_c[T_LO]  = cur_x < thr_arr[T_LO];
   assign raw_c[T_VLO] = below_vlo;

   assign dly_arr[T_VHI] = vhi_secs;
   assign dly_arr[T_HI]  = hi_secs;
   assign dly_arr[T_LO]  = lo_secs;
   assign dly_arr[T_VLO] = vlo_secs;

   assign clr_req = {(N_LATCH+1){wr_en}} & ~wr_data[N_LATCH:0];

   for (genvar g = 0; g < N_LATCH; g++) begin : g_lat
      ba_timer #(.TW(TIME_W)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (sec_tick),
         .cond    (have_q && run_on && raw_c[g]),
         .restart (clr_req[g]),
         .limit   (dly_arr[g]),
         .expired (lat_exp[g])
      );
   end

   assign set_req = {off_exp, lat_exp};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lat_q <= '0;
      else
         lat_q <= (lat_q | set_req) & ~clr_req;
   end

   // ---------------- non-latching alarms ----------------
   logic nl_up, nl_dn;

   ba_hyst #(.XW(XW), .UP_SIDE(1'b1)) u_nl_up (
      .clk (clk), .rst_n (rst_n), .en (have_q), .cur (cur_x),
      .thr (thr_arr[T_NUP]), .band (band_up), .flag (nl_up)
   );
   ba_hyst #(.XW(XW), .UP_SIDE(1'b0)) u_nl_dn (
      .clk (clk), .rst_n (rst_n), .en (have_q), .cur (cur_x),
      .thr (thr_arr[T_NDN]), .band (band_dn), .flag (nl_dn)
   );

   logic unused_wr;
   assign unused_wr = ^wr_data[STS_W-1:N_LATCH+1];

   assign rd_status = {6'b0, nl_dn, nl_up, 3'b0, lat_q};
endmodule

// File: rtl/ba_mon_chk.sv
`timescale 1ns/1ps
module ba_mon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [4:0] wr_lo,
   input logic [4:0] sts_lo,
   input logic       run_on
);
   // R10: without a write, latched bits never fall
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((sts_lo & $past(sts_lo)) == $past(sts_lo)));

   // R3: bits written as 0 read 0 after the write
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((sts_lo & ~$past(wr_lo)) == 5'b0));

   // R4: a latching level alarm rises only while the load was running
   p_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts_lo[3:0] & ~$past(sts_lo[3:0]))) |-> $past(run_on));

   // R5: load-lost bit rises only out of the running state
   p_lost_after_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_lo[4]) |-> $past(run_on));
endmodule

bind branch_alarm_monitor ba_mon_chk u_ba_mon_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_lo  (wr_data[4:0]),
   .sts_lo (rd_status[4:0]),
   .run_on (run_on)
);

// File: tb/test_branch_alarm_monitor.sv
`timescale 1ns/1ps
module test_branch_alarm_monitor;
   localparam int CW = 8;
   localparam int PW = 7;
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic          sample_vld = 1'b0;
   logic [CW-1:0] sample_amps = '0;
   logic [CW-1:0] rating_amps = '0;
   logic [PW-1:0] vhi_pct = '0, hi_pct = '0, lo_pct = '0, vlo_pct = '0;
   logic [PW-1:0] nl_up_pct = '0, nl_dn_pct = '0, band_pct = '0;
   logic [TW-1:0] vhi_secs = '0, hi_secs = '0, lo_secs = '0, vlo_secs = '0;
   logic [TW-1:0] on_secs = '0, off_secs = '0;
   logic          wr_en = 1'b0;
   logic [15:0]   wr_data = '0;
   logic [15:0]   rd_status;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   branch_alarm_monitor #(.CUR_W(CW), .PCT_W(PW), .TIME_W(TW)) i_branch_alarm_monitor (
      .clk (clk), .rst_n (rst_n), .sec_tick (sec_tick),
      .sample_vld (sample_vld), .sample_amps (sample_amps),
      .rating_amps (rating_amps),
      .vhi_pct (vhi_pct), .hi_pct (hi_pct), .lo_pct (lo_pct), .vlo_pct (vlo_pct),
      .nl_up_pct (nl_up_pct), .nl_dn_pct (nl_dn_pct), .band_pct (band_pct),
      .vhi_secs (vhi_secs), .hi_secs (hi_secs), .lo_secs (lo_secs),
      .vlo_secs (vlo_secs), .on_secs (on_secs), .off_secs (off_secs),
      .wr_en (wr_en), .wr_data (wr_data), .rd_status (rd_status)
   );

   task automatic chk(input string rq, input logic [15:0] exp);
      n_chk++;
      if (rd_status !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", rq, rd_status, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put_sample(input int v);
      @(negedge clk);
      sample_amps = CW'(v);
      sample_vld  = 1'b1;
      @(negedge clk) sample_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic sw_write(input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk) wr_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // non-latching sweep with arithmetic model
   task automatic sweep(input int brk, input int up, input int dn, input int hy);
      int tu, td, bu, bd;
      logic eu, ed;
      logic [15:0] exp;
      rating_amps = CW'(brk);
      nl_up_pct   = PW'(up);
      nl_dn_pct   = PW'(dn);
      band_pct    = PW'(hy);
      on_secs     = '1;
      vlo_pct     = '0;
      do_reset();
      tu = brk * up / 100;  bu = tu * hy / 100;
      td = brk * dn / 100;  bd = td * hy / 100;
      eu = 1'b0; ed = 1'b0;
      for (int d = 0; d < 2; d++) begin
         for (int k = 0; k < 256; k++) begin
            int v;
            v = (d == 0) ? k : 255 - k;
            put_sample(v);
            if (v > tu) eu = 1'b1;
            else if (v + bu < tu) eu = 1'b0;
            if (v < td) ed = 1'b1;
            else if (v > td + bd) ed = 1'b0;
            exp = 16'h0;
            exp[8] = eu;
            exp[9] = ed;
            chk("R8 R9 R7 R2", exp);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R7/R8/R9 sweeps over rounding and strict-compare boundaries
      sweep(200, 60, 40, 10);
      sweep(37, 50, 30, 25);
      sweep(255, 100, 20, 0);
      sweep(99, 73, 51, 60);

      // latching scenario: thresholds 90/80/30/20, nl 85 (band 8) and 40 (band 4)
      rating_amps = 8'd100;
      vhi_pct = 7'd90; hi_pct = 7'd80; lo_pct = 7'd30; vlo_pct = 7'd20;
      nl_up_pct = 7'd85; nl_dn_pct = 7'd40; band_pct = 7'd10;
      vhi_secs = 4'd0; hi_secs = 4'd2; lo_secs = 4'd1; vlo_secs = 4'd3;
      on_secs = 4'd3; off_secs = 4'd2;
      do_reset();
      chk("R1 reset", 16'h0000);

      put_sample(10);
      repeat (5) tick();
      chk("R5 no lost without run, R1", 16'h0200);

      put_sample(95);
      tick(); tick();
      chk("R4 not armed before run", 16'h0100);
      tick();
      chk("R4 armed, R6 zero delay", 16'h0101);
      tick();
      chk("R6 high delay pending", 16'h0101);
      tick();
      chk("R6 high delay reached", 16'h0103);

      sw_write(16'hFFFF);
      chk("R3 ones keep bits", 16'h0103);
      sw_write(16'h0000);
      chk("R3 clear, nl ignores write, R10 zero-delay reset", 16'h0101);
      tick();
      chk("R10 new full delay after clear", 16'h0101);
      tick();
      chk("R10 resets after full delay", 16'h0103);

      sw_write(16'hFFFD);
      chk("R3 single bit clear", 16'h0101);
      tick();
      put_sample(70);
      chk("R10 latched hold, R8 clear", 16'h0001);
      put_sample(95);
      chk("R8 set again", 16'h0101);
      tick();
      chk("R6 count restarted after lapse", 16'h0101);
      tick();
      chk("R6 set after restart", 16'h0103);

      put_sample(25);
      sw_write(16'h0000);
      chk("R3 clear, R9 set", 16'h0200);
      tick();
      chk("R6 low delay one", 16'h0204);

      put_sample(10);
      tick();
      chk("R5 lost pending", 16'h0204);
      tick();
      chk("R5 lost declared", 16'h0214);
      tick(); tick();
      chk("R4 very-low disarmed after lost", 16'h0214);
      sw_write(16'hFFEF);
      chk("R3 clear lost bit", 16'h0204);

      put_sample(50);
      tick(); tick(); tick();
      chk("R4 run again, R9 clear", 16'h0004);
      off_secs = 4'd15;
      put_sample(10);
      tick(); tick();
      chk("R6 very-low pending", 16'h0204);
      tick();
      chk("R6 very-low set", 16'h020C);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule